// File: doc/BRIEF.md
# Branch Target and Condition Resolver

This unit resolves one branch instruction of a 32-bit core with big-endian bit numbering, where bit 0 is the most significant bit. It recognises four instruction forms: the unconditional branch, the conditional branch, the conditional branch through the link register, and the conditional branch through the count register. It evaluates the branch against the condition register (CR) and the count register (CTR). It returns the next instruction address and a taken flag. It also returns write enables and new values for the link register (LR) and for CTR.

A valid strobe accompanies the instruction word, the current instruction address and the three register values. All results are registered and appear on the cycle after the strobe. The surrounding core applies the LR and CTR writes. The address width is a parameter. The instruction and CR layouts are fixed at 32 bits.

Top module: `brr_resolve`

## Requirements
- R1: Opcode `instr[31:26]`=18 is the unconditional branch, and it is always taken. Its displacement is `instr[25:2]`, shifted left by 2 and sign-extended. With `instr[1]` (absolute flag) set, the displacement is the target. With the flag clear, the target is the current address plus the displacement.
- R2: For any recognised form with `instr[0]` (link flag) set, `lr_we_o` is 1 and `lr_wdata_o` is the current address plus 4, whether or not the branch is taken. With the link flag clear, `lr_we_o` is 0.
- R3: Opcode 16 is the conditional branch, with field bo=`instr[25:21]`, bi=`instr[20:16]` and a 14-bit displacement `instr[15:2]`. The displacement is shifted left by 2, sign-extended, and made relative or absolute by `instr[1]`. The condition test passes when bo[4] is 1, or when CR bit `cr_i[31-bi]` equals bo[3].
- R4: For opcode 16, and for opcode 19 with `instr[10:1]`=16, a clear bo[2] makes the block decrement CTR. `ctr_we_o` is then 1 and `ctr_wdata_o` is `ctr_i`-1. This holds even when the branch is not taken.
- R5: For the forms that decrement CTR, the count test passes when bo[2] is 1, or when (decremented CTR ≠ 0) XOR bo[1] is 1. With `ctr_i`=1 and bo[1]=0, the count test fails.
- R6: Opcode 19 with `instr[10:1]`=528 uses only the condition test, never writes CTR, and targets `ctr_i` with its two low bits cleared.
- R7: Opcode 19 with `instr[10:1]`=16 targets `lr_i` with its two low bits cleared. The old LR value is used even when the link flag is set.
- R8: A branch is taken only when both its count test and its condition test pass. When it is not taken, `next_ia_o` is the current address plus 4.
- R9: Any other instruction word gives `taken_o`=0, `next_ia_o` = current address plus 4, and both write enables at 0.
- R10: Outputs are registered. `out_vld_o` is 1 exactly on the cycle after a cycle with `valid_i`=1. When `out_vld_o` is 0, `taken_o`, `lr_we_o` and `ctr_we_o` are 0.
- R11: While reset is asserted, and until it has been released through two synchronising stages, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction and operands are valid this cycle |
| instr_i | input | 32 | Instruction word |
| cia_i | input | XLEN | Current instruction address |
| cr_i | input | 32 | Condition register |
| lr_i | input | XLEN | Link register value |
| ctr_i | input | XLEN | Count register value |
| out_vld_o | output | 1 | Results valid |
| next_ia_o | output | XLEN | Next instruction address |
| taken_o | output | 1 | Branch taken |
| lr_we_o | output | 1 | Write LR |
| lr_wdata_o | output | XLEN | New LR value |
| ctr_we_o | output | 1 | Write CTR |
| ctr_wdata_o | output | XLEN | New CTR value |

## Verification
The unconditional branch is run with positive and negative displacements and with both addressing modes. This separates the sign extension from the relative-versus-absolute choice. The conditional forms sweep the bo bits against set and clear CR bits and against CTR values of 1, 2 and 0. This isolates the condition test from the count test, and shows whether the count test reads CTR before or after the decrement. The link-register form is run with the link flag set, to confirm that the target uses the old LR. Random encodings mixed with unknown opcodes and wrong extended opcodes confirm that unrecognised words write nothing.

// File: rtl/brr_pkg.sv
package brr_pkg;

  localparam logic [5:0] OPC_BRANCH = 6'd18;
  localparam logic [5:0] OPC_BCOND  = 6'd16;
  localparam logic [5:0] OPC_XL     = 6'd19;
  localparam logic [9:0] XO_TO_LR   = 10'd16;
  localparam logic [9:0] XO_TO_CTR  = 10'd528;

  typedef enum logic [2:0] {
    FORM_NONE  = 3'd0,
    FORM_UNC   = 3'd1,
    FORM_COND  = 3'd2,
    FORM_VIALR = 3'd3,
    FORM_VICTR = 3'd4
  } form_e;

  typedef struct packed {
    logic cond_ign;   // condition test always passes
    logic cond_val;   // required CR bit value
    logic ctr_ign;    // no decrement, count test passes
    logic ctr_zero;   // invert the nonzero sense
    logic hint;       // unused by resolution
  } bo_t;

endpackage

// File: rtl/brr_decode.sv
module brr_decode
  import brr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  output form_e           form,
  output bo_t             bo,
  output logic [4:0]      bi,
  output logic            absolute,
  output logic            link,
  output logic [XLEN-1:0] disp
);
  localparam int LI_W = 24;
  localparam int BD_W = 14;

  logic [5:0]      opc;
  logic [9:0]      xo;
  logic [LI_W-1:0] li;
  logic [BD_W-1:0] bd;
  logic [XLEN-1:0] li_ext;
  logic [XLEN-1:0] bd_ext;

  assign opc      = instr[31:26];
  assign xo       = instr[10:1];
  assign li       = instr[25:2];
  assign bd       = instr[15:2];
  assign bo       = bo_t'(instr[25:21]);
  assign bi       = instr[20:16];
  assign absolute = instr[1];
  assign link     = instr[0];

  assign li_ext = {{(XLEN-LI_W-2){li[LI_W-1]}}, li, 2'b00};
  assign bd_ext = {{(XLEN-BD_W-2){bd[BD_W-1]}}, bd, 2'b00};

  always_comb begin
    form = FORM_NONE;
    unique case (opc)
      OPC_BRANCH: form = FORM_UNC;
      OPC_BCOND:  form = FORM_COND;
      OPC_XL: begin
        if (xo == XO_TO_LR)       form = FORM_VIALR;
        else if (xo == XO_TO_CTR) form = FORM_VICTR;
        else                      form = FORM_NONE;
      end
      default:    form = FORM_NONE;
    endcase
  end

  assign disp = (form == FORM_UNC) ? li_ext : bd_ext;

endmodule

// File: rtl/brr_cond.sv
module brr_cond
  import brr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  form_e           form,
  input  bo_t             bo,
  input  logic [4:0]      bi,
  input  logic [31:0]     cr,
  input  logic [XLEN-1:0] ctr,
  output logic            dec_ctr,
  output logic [XLEN-1:0] ctr_next,
  output logic            go
);
  logic uses_count;
  logic cr_bit;
  logic count_ok;
  logic cond_ok;

  assign uses_count = (form == FORM_COND) || (form == FORM_VIALR);
  assign dec_ctr    = uses_count && !bo.ctr_ign;
  assign ctr_next   = ctr - XLEN'(1);
  assign cr_bit     = cr[5'd31 - bi];

  always_comb begin
    count_ok = 1'b1;
    if (uses_count && !bo.ctr_ign)
      count_ok = (ctr_next != '0) ^ bo.ctr_zero;
  end

  always_comb begin
    unique case (form)
      FORM_UNC:  cond_ok = 1'b1;
      FORM_NONE: cond_ok = 1'b0;
      default:   cond_ok = bo.cond_ign || (cr_bit == bo.cond_val);
    endcase
  end

  assign go = count_ok && cond_ok;

endmodule

// File: rtl/brr_target.sv
module brr_target
  import brr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  form_e           form,
  input  logic            absolute,
  input  logic [XLEN-1:0] disp,
  input  logic [XLEN-1:0] cia,
  input  logic [XLEN-1:0] lr,
  input  logic [XLEN-1:0] ctr,
  input  logic            go,
  output logic [XLEN-1:0] next_ia,
  output logic [XLEN-1:0] seq_ia
);
  localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(3);

  logic [XLEN-1:0] rel_or_abs;
  logic [XLEN-1:0] target;

  assign seq_ia     = cia + XLEN'(4);
  assign rel_or_abs = absolute ? disp : (cia + disp);

  always_comb begin
    unique case (form)
      FORM_VIALR: target = lr & WORD_MASK;
      FORM_VICTR: target = ctr & WORD_MASK;
      default:    target = rel_or_abs;
    endcase
  end

  assign next_ia = go ? target : seq_ia;

endmodule

// File: rtl/brr_resolve.sv
module brr_resolve
  import brr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] cia_i,
  input  logic [31:0]     cr_i,
  input  logic [XLEN-1:0] lr_i,
  input  logic [XLEN-1:0] ctr_i,
  output logic            out_vld_o,
  output logic [XLEN-1:0] next_ia_o,
  output logic            taken_o,
  output logic            lr_we_o,
  output logic [XLEN-1:0] lr_wdata_o,
  output logic            ctr_we_o,
  output logic [XLEN-1:0] ctr_wdata_o
);
  localparam int SYNC_STAGES = 2;

  // reset: asserted at once, released through a short shift chain
  logic [SYNC_STAGES-1:0] rst_chain_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= '0;
    else        rst_chain_q <= {rst_chain_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_chain_q[SYNC_STAGES-1];

  form_e           form;
  bo_t             bo;
  logic [4:0]      bi;
  logic            absolute;
  logic            link;
  logic [XLEN-1:0] disp;
  logic            dec_ctr;
  logic [XLEN-1:0] ctr_next;
  logic            go;
  logic [XLEN-1:0] next_ia;
  logic [XLEN-1:0] seq_ia;

  brr_decode #(.XLEN(XLEN)) u_dec (
    .instr(instr_i), .form(form), .bo(bo), .bi(bi),
    .absolute(absolute), .link(link), .disp(disp)
  );

  brr_cond #(.XLEN(XLEN)) u_cond (
    .form(form), .bo(bo), .bi(bi), .cr(cr_i), .ctr(ctr_i),
    .dec_ctr(dec_ctr), .ctr_next(ctr_next), .go(go)
  );

  brr_target #(.XLEN(XLEN)) u_tgt (
    .form(form), .absolute(absolute), .disp(disp), .cia(cia_i),
    .lr(lr_i), .ctr(ctr_i), .go(go), .next_ia(next_ia), .seq_ia(seq_ia)
  );

  // next-state
  logic            vld_d, taken_d, lr_we_d, ctr_we_d;
  logic [XLEN-1:0] next_d, lr_wd_d, ctr_wd_d;
  logic            data_en;
  logic            known;

  assign known   = (form != FORM_NONE);
  assign data_en = valid_i;

  always_comb begin
    vld_d    = valid_i;
    taken_d  = valid_i && known && go;
    lr_we_d  = valid_i && known && link;
    ctr_we_d = valid_i && dec_ctr;
    next_d   = next_ia;
    lr_wd_d  = seq_ia;
    ctr_wd_d = ctr_next;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_vld_o <= 1'b0;
      taken_o   <= 1'b0;
      lr_we_o   <= 1'b0;
      ctr_we_o  <= 1'b0;
    end else begin
      out_vld_o <= vld_d;
      taken_o   <= taken_d;
      lr_we_o   <= lr_we_d;
      ctr_we_o  <= ctr_we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      next_ia_o   <= '0;
      lr_wdata_o  <= '0;
      ctr_wdata_o <= '0;
    end else if (data_en) begin
      next_ia_o   <= next_d;
      lr_wdata_o  <= lr_wd_d;
      ctr_wdata_o <= ctr_wd_d;
    end
  end

endmodule

// File: rtl/brr_resolve_chk.sv
module brr_resolve_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] cia_i,
  input logic [XLEN-1:0] ctr_i,
  input logic            out_vld_o,
  input logic [XLEN-1:0] next_ia_o,
  input logic            taken_o,
  input logic            lr_we_o,
  input logic [XLEN-1:0] lr_wdata_o,
  input logic            ctr_we_o,
  input logic [XLEN-1:0] ctr_wdata_o
);
  logic is_victr;
  logic is_known;

  assign is_victr = (instr_i[31:26] == 6'd19) && (instr_i[10:1] == 10'd528);
  assign is_known = (instr_i[31:26] == 6'd18) || (instr_i[31:26] == 6'd16) ||
                    ((instr_i[31:26] == 6'd19) &&
                     ((instr_i[10:1] == 10'd16) || (instr_i[10:1] == 10'd528)));

  p_vld_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> out_vld_o);

  p_vld_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !out_vld_o);

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld_o |-> (!taken_o && !lr_we_o && !ctr_we_o));

  p_link_val_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && is_known && instr_i[0]) |=> (lr_we_o && lr_wdata_o == $past(cia_i) + XLEN'(4)));

  p_ctr_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ctr_we_o == 1'b0) |=> (!ctr_we_o || ctr_wdata_o == $past(ctr_i) - XLEN'(1)));

  p_victr_nowr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && is_victr) |=> !ctr_we_o);

  p_seq_nt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i) |=> (taken_o || next_ia_o == $past(cia_i) + XLEN'(4)));

  p_unknown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !is_known) |=> (!taken_o && !lr_we_o && !ctr_we_o));

endmodule

bind brr_resolve brr_resolve_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .valid_i(valid_i), .instr_i(instr_i),
  .cia_i(cia_i), .ctr_i(ctr_i), .out_vld_o(out_vld_o), .next_ia_o(next_ia_o),
  .taken_o(taken_o), .lr_we_o(lr_we_o), .lr_wdata_o(lr_wdata_o),
  .ctr_we_o(ctr_we_o), .ctr_wdata_o(ctr_wdata_o)
);

// File: tb/brr_resolve_tb.sv
module brr_resolve_tb;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            valid_i;
  logic [31:0]     instr_i;
  logic [XLEN-1:0] cia_i, lr_i, ctr_i;
  logic [31:0]     cr_i;
  logic            out_vld_o, taken_o, lr_we_o, ctr_we_o;
  logic [XLEN-1:0] next_ia_o, lr_wdata_o, ctr_wdata_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4ns clk = ~clk;

  brr_resolve #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .cia_i(cia_i), .cr_i(cr_i), .lr_i(lr_i), .ctr_i(ctr_i),
    .out_vld_o(out_vld_o), .next_ia_o(next_ia_o), .taken_o(taken_o),
    .lr_we_o(lr_we_o), .lr_wdata_o(lr_wdata_o),
    .ctr_we_o(ctr_we_o), .ctr_wdata_o(ctr_wdata_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_b(input logic [23:0] li, input logic aa, input logic lk);
    return {6'd18, li, aa, lk};
  endfunction
  function automatic logic [31:0] enc_bc(input logic [4:0] bo, input logic [4:0] bi,
                                         input logic [13:0] bd, input logic aa, input logic lk);
    return {6'd16, bo, bi, bd, aa, lk};
  endfunction
  function automatic logic [31:0] enc_xl(input logic [4:0] bo, input logic [4:0] bi,
                                         input logic [9:0] xo, input logic lk);
    return {6'd19, bo, bi, 5'd0, xo, lk};
  endfunction

  // reference model written from the requirements
  task automatic model(input logic [31:0] ins, input logic [31:0] cia, input logic [31:0] cr,
                       input logic [31:0] lr, input logic [31:0] ctr,
                       output logic [31:0] nxt, output logic tk, output logic lwe,
                       output logic [31:0] lwd, output logic cwe, output logic [31:0] cwd);
    logic [4:0] bo; logic [4:0] bi; logic [9:0] xo;
    logic is_b, is_c, is_l, is_t, cnt_ok, cnd_ok;
    logic [31:0] c, tgt;
    bo = ins[25:21]; bi = ins[20:16]; xo = ins[10:1];
    is_b = ins[31:26] == 6'd18;
    is_c = ins[31:26] == 6'd16;
    is_l = ins[31:26] == 6'd19 && xo == 10'd16;
    is_t = ins[31:26] == 6'd19 && xo == 10'd528;
    nxt = cia + 4; tk = 0; lwe = 0; cwe = 0;
    lwd = cia + 4; cwd = ctr - 1;
    if (!(is_b || is_c || is_l || is_t)) return;
    lwe = ins[0];
    c = ctr; cnt_ok = 1;
    if ((is_c || is_l) && !bo[2]) begin
      c = ctr - 1; cwe = 1;
      cnt_ok = (c != 0) ^ bo[1];
    end
    cnd_ok = is_b ? 1'b1 : (bo[4] || (cr[31 - bi] == bo[3]));
    tk = cnt_ok && cnd_ok;
    if (is_b)      tgt = {{6{ins[25]}}, ins[25:2], 2'b00};
    else if (is_c) tgt = {{16{ins[15]}}, ins[15:2], 2'b00};
    else if (is_l) tgt = lr & ~32'd3;
    else           tgt = ctr & ~32'd3;
    if ((is_b || is_c) && !ins[1]) tgt = cia + tgt;
    if (tk) nxt = tgt;
  endtask

  task automatic run(input string req, input logic [31:0] ins, input logic [31:0] cia,
                     input logic [31:0] cr, input logic [31:0] lr, input logic [31:0] ctr);
    logic [31:0] e_n, e_lw, e_cw; logic e_t, e_lwe, e_cwe;
    @(negedge clk);
    valid_i = 1; instr_i = ins; cia_i = cia; cr_i = cr; lr_i = lr; ctr_i = ctr;
    model(ins, cia, cr, lr, ctr, e_n, e_t, e_lwe, e_lw, e_cwe, e_cw);
    @(negedge clk);
    valid_i = 0;
    chk(req, "out_vld", 32'(out_vld_o), 32'd1);
    chk(req, "next_ia", next_ia_o, e_n);
    chk(req, "taken", 32'(taken_o), 32'(e_t));
    chk(req, "lr_we", 32'(lr_we_o), 32'(e_lwe));
    if (e_lwe) chk(req, "lr_wdata", lr_wdata_o, e_lw);
    chk(req, "ctr_we", 32'(ctr_we_o), 32'(e_cwe));
    if (e_cwe) chk(req, "ctr_wdata", ctr_wdata_o, e_cw);
  endtask

  task automatic t_reset;
    chk("R11", "out_vld", 32'(out_vld_o), 0);
    chk("R11", "next_ia", next_ia_o, 0);
    chk("R11", "taken", 32'(taken_o), 0);
    chk("R11", "we", 32'({lr_we_o, ctr_we_o}), 0);
    chk("R11", "wdata", lr_wdata_o | ctr_wdata_o, 0);
  endtask

  task automatic t_uncond;
    run("R1", enc_b(24'h000010, 0, 0), 32'h0000_1000, 0, 0, 0);     // +0x40
    run("R1", enc_b(24'hFFFFF0, 0, 0), 32'h0000_1000, 0, 0, 0);     // -0x40
    run("R1", enc_b(24'h000123, 1, 0), 32'h0000_1000, 0, 0, 0);     // absolute
    run("R1", enc_b(24'h800000, 1, 0), 32'h0000_1000, 0, 0, 0);     // absolute negative
    run("R2", enc_b(24'h000004, 0, 1), 32'h0000_2000, 0, 0, 0);
  endtask

  task automatic t_cond;
    // bo=5'b01100: ignore count, require CR bit = 1
    run("R3", enc_bc(5'b01100, 5'd0, 14'h0008, 0, 0), 32'h100, 32'h8000_0000, 0, 5);
    run("R3", enc_bc(5'b01100, 5'd0, 14'h0008, 0, 0), 32'h100, 32'h0000_0000, 0, 5);
    run("R3", enc_bc(5'b00100, 5'd31, 14'h3FF8, 0, 0), 32'h100, 32'h0000_0000, 0, 5);
    run("R3", enc_bc(5'b10100, 5'd7, 14'h0010, 1, 0), 32'h100, 32'hFFFF_FFFF, 0, 5);
    run("R2", enc_bc(5'b01100, 5'd2, 14'h0004, 0, 1), 32'h300, 32'h0000_0000, 0, 5);
  endtask

  task automatic t_ctr;
    // bo=5'b10000: decrement, branch if new CTR nonzero
    run("R4", enc_bc(5'b10000, 5'd0, 14'h0010, 0, 0), 32'h400, 0, 0, 32'd2);
    run("R5", enc_bc(5'b10000, 5'd0, 14'h0010, 0, 0), 32'h400, 0, 0, 32'd1);
    run("R5", enc_bc(5'b10010, 5'd0, 14'h0010, 0, 0), 32'h400, 0, 0, 32'd1);
    run("R5", enc_bc(5'b10010, 5'd0, 14'h0010, 0, 0), 32'h400, 0, 0, 32'd0);
    run("R4", enc_xl(5'b10000, 5'd0, 10'd16, 0), 32'h400, 0, 32'h888, 32'd1);
  endtask

  task automatic t_vialr;
    run("R7", enc_xl(5'b10100, 5'd0, 10'd16, 0), 32'h500, 0, 32'h1237, 9);
    run("R7", enc_xl(5'b10100, 5'd0, 10'd16, 1), 32'h500, 0, 32'h1237, 9);
  endtask

  task automatic t_victr;
    run("R6", enc_xl(5'b10000, 5'd0, 10'd528, 0), 32'h600, 0, 0, 32'h4443);
    run("R6", enc_xl(5'b00000, 5'd3, 10'd528, 1), 32'h600, 32'h1000_0000, 0, 32'h4443);
    run("R6", enc_xl(5'b00000, 5'd3, 10'd528, 0), 32'h600, 32'h0000_0000, 0, 32'h4443);
  endtask

  task automatic t_notaken;
    run("R8", enc_bc(5'b01100, 5'd4, 14'h0100, 0, 0), 32'h700, 32'h0000_0000, 0, 3);
    run("R8", enc_xl(5'b00100, 5'd4, 10'd16, 0), 32'h700, 32'h0800_0000, 32'h900, 3);
  endtask

  task automatic t_unknown;
    run("R9", {6'd17, 26'h3FF_FFFF}, 32'h800, 32'hFFFF_FFFF, 32'h10, 32'h10);
    run("R9", enc_xl(5'b10100, 5'd0, 10'd17, 1), 32'h800, 0, 32'h10, 32'h10);
    run("R9", {6'd0, 26'h000_0001}, 32'h800, 0, 32'h10, 32'h10);
  endtask

  task automatic t_idle;
    @(negedge clk);
    instr_i = enc_b(24'h1, 0, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10", "idle out_vld", 32'(out_vld_o), 0);
      chk("R10", "idle enables", 32'({taken_o, lr_we_o, ctr_we_o}), 0);
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ins;
      int sel;
      sel = $urandom_range(0, 5);
      ins = $urandom;
      case (sel)
        0: ins[31:26] = 6'd18;
        1: ins[31:26] = 6'd16;
        2: begin ins[31:26] = 6'd19; ins[10:1] = 10'd16; end
        3: begin ins[31:26] = 6'd19; ins[10:1] = 10'd528; end
        default: ;
      endcase
      run("R8", ins, $urandom & 32'hFFFF_FFFC, $urandom, $urandom,
          ($urandom_range(0, 3) == 0) ? 32'd1 : 32'($urandom_range(0, 3)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; valid_i = 0; instr_i = 0; cia_i = 0; cr_i = 0; lr_i = 0; ctr_i = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    repeat (2) @(negedge clk);
    t_uncond;
    t_cond;
    t_ctr;
    t_vialr;
    t_victr;
    t_notaken;
    t_unknown;
    t_idle;
    t_random;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule